// File: doc/BRIEF.md
# MSI Ring-Buffer Event Logger

This block takes in message-signalled interrupt writes, each carrying a 16-bit vector number. It records each one as a 16-byte entry in a ring buffer that lives in system memory. A small register bus sets the buffer's base address, its size and its policies. Software consumes entries and then writes back the read offset. While unread entries remain, the block raises a level interrupt.

Each accepted vector becomes one memory write request. The request carries the full entry address and a 128-bit entry, and only one request is in flight at a time. The inbound port stays stalled until the memory side acknowledges that request.

Two optional policies cover a buffer that has caught up with its reader. Full detection can drop the new vector and set a sticky flag. It can instead overwrite the oldest entry, pushing the read offset forward.

Top module: `msi_ring_logger`

## Requirements
- R1: After reset, all registers read zero, `irq_o` and `mem_req_o` are low and `msi_ready_o` is high.
- R2: The register word addresses are as follows: 0 holds control, 3 the base-address upper half, 4 the base-address lower half, 5 the read offset and 6 the write offset. The control bits are as follows:
  - bit 0: logging enable;
  - bit 1: full detection;
  - bit 3: interrupt enable;
  - bit 4: stop-when-full;
  - bits 9:8: size select;
  - bit 16: overflow flag (read-only).

  Unused control bits read zero. The lower base half and both offsets keep bits 3:0 at zero.
- R3: An entry goes to the address {base upper, base lower} + (write offset AND mask). The mask is 2^(sel+15)-1 with bits 3:0 cleared, so sel 0..3 selects 32, 64, 128 or 256 KB.
- R4: Entry bits 15:0 hold the vector, with the low byte in byte 0. Bits 127:16 are zero.
- R5: `msi_ready_o` is low from the acceptance of a vector until the cycle after `mem_ack_i`. While `mem_ack_i` is low, `mem_req_o`, `mem_addr_o` and `mem_data_o` hold steady.
- R6: The write offset advances by exactly 16 on each acknowledged entry. It is a raw 32-bit counter that does not wrap at the buffer size.
- R7: With enable clear, vectors are accepted and discarded. No request is issued and the offsets do not change.
- R8: `irq_o` is high exactly when enable and interrupt enable are both set and the masked read and write offsets differ. Clearing those two bits drops the interrupt and leaves the other control bits as written.
- R9: When full detection and stop-when-full are set, a vector that arrives while (masked write offset + 16) AND mask equals the masked read offset is dropped and sets the overflow flag. Writing control with bit 16 set clears the flag.
- R10: When full detection is set and stop-when-full is clear, an entry logged into a full buffer is written. At its acknowledge, the read offset also advances by 16 within the mask.
- R11: With full detection clear, no full check is made, and every vector is logged.
- R12: A register write to an offset in the same cycle as a hardware update of that offset takes effect, and the hardware update is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| msi_valid_i | input | 1 | Inbound vector valid |
| msi_vec_i | input | 16 | Inbound vector number |
| msi_ready_o | output | 1 | Inbound vector ready |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 64 | Entry byte address |
| mem_data_o | output | 128 | Entry contents |
| mem_ack_i | input | 1 | Memory write acknowledge |
| irq_o | output | 1 | Level interrupt |

## Verification
Two updates can fall in the same cycle. In one, the memory acknowledge advances the write offset or, in overwrite mode, the read offset. In the other, a software register write hits the same offset. The bench raises `mem_ack_i` and `reg_we_i` on the same clock edge, once against the read offset and once against the write offset. It then reads back both offsets and the interrupt level. Every readback is judged against the software value taking priority, while the hardware increment of the other offset still lands.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int DW          = 32;
  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_W     = ENTRY_BYTES * 8;
  localparam int ALIGN_W     = $clog2(ENTRY_BYTES);

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd3;
  localparam logic [2:0] RA_BASE_LO = 3'd4;
  localparam logic [2:0] RA_RD_OFS  = 3'd5;
  localparam logic [2:0] RA_WR_OFS  = 3'd6;

  localparam int CB_EN    = 0;
  localparam int CB_FULL  = 1;
  localparam int CB_IRQ   = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_SEL   = 8;
  localparam int CB_OVF   = 16;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int MIN_EXP = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              hw_wofs_inc_i,
  input  logic              hw_rofs_inc_i,
  input  logic              hw_ovf_set_i,
  output logic              en_o,
  output logic              full_det_o,
  output logic              irq_en_o,
  output logic              stop_o,
  output logic [2*DW-1:0]   base_o,
  output logic [DW-1:0]     rofs_o,
  output logic [DW-1:0]     wofs_o,
  output logic [DW-1:0]     mask_o
);
  localparam logic [DW-1:0] STEP  = DW'(ENTRY_BYTES);
  localparam logic [DW-1:0] ALIGN = ~DW'(ENTRY_BYTES - 1);

  logic [SEL_W-1:0] sel_q;
  logic             ovf_q;
  logic [DW-1:0]    base_hi_q, base_lo_q;

  wire wr_ctrl = reg_we_i && reg_addr_i == RA_CTRL;
  wire wr_rofs = reg_we_i && reg_addr_i == RA_RD_OFS;
  wire wr_wofs = reg_we_i && reg_addr_i == RA_WR_OFS;

  always_comb begin
    mask_o = ((DW'(1) << (int'(sel_q) + MIN_EXP)) - DW'(1)) & ALIGN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0; full_det_o <= 1'b0; irq_en_o <= 1'b0; stop_o <= 1'b0;
      sel_q <= '0; ovf_q <= 1'b0;
      base_hi_q <= '0; base_lo_q <= '0; rofs_o <= '0; wofs_o <= '0;
    end else begin
      if (wr_ctrl) begin
        en_o       <= reg_wdata_i[CB_EN];
        full_det_o <= reg_wdata_i[CB_FULL];
        irq_en_o   <= reg_wdata_i[CB_IRQ];
        stop_o     <= reg_wdata_i[CB_STOP];
        sel_q      <= reg_wdata_i[CB_SEL +: SEL_W];
      end
      // a new overflow beats a simultaneous clear
      if (hw_ovf_set_i) ovf_q <= 1'b1;
      else if (wr_ctrl && reg_wdata_i[CB_OVF]) ovf_q <= 1'b0;
      if (reg_we_i && reg_addr_i == RA_BASE_HI) base_hi_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_BASE_LO) base_lo_q <= reg_wdata_i & ALIGN;
      if (wr_rofs)            rofs_o <= reg_wdata_i & ALIGN;
      else if (hw_rofs_inc_i) rofs_o <= (rofs_o + STEP) & mask_o;
      if (wr_wofs)            wofs_o <= reg_wdata_i & ALIGN;
      else if (hw_wofs_inc_i) wofs_o <= wofs_o + STEP;
    end
  end

  assign base_o = {base_hi_q, base_lo_q};

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[CB_EN]            = en_o;
        reg_rdata_o[CB_FULL]          = full_det_o;
        reg_rdata_o[CB_IRQ]           = irq_en_o;
        reg_rdata_o[CB_STOP]          = stop_o;
        reg_rdata_o[CB_SEL +: SEL_W]  = sel_q;
        reg_rdata_o[CB_OVF]           = ovf_q;
      end
      RA_BASE_HI: reg_rdata_o = base_hi_q;
      RA_BASE_LO: reg_rdata_o = base_lo_q;
      RA_RD_OFS:  reg_rdata_o = rofs_o;
      RA_WR_OFS:  reg_rdata_o = wofs_o;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R6
  wofs_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_wofs_inc_i && !wr_wofs |=> wofs_o == $past(wofs_o) + STEP);
  // R6
  wofs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_wofs_inc_i && !wr_wofs |=> $stable(wofs_o));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !(wr_ctrl && reg_wdata_i[CB_OVF]) |=> ovf_q);
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               full_det_i,
  input  logic               stop_i,
  input  logic [DW-1:0]      mask_i,
  input  logic [DW-1:0]      rofs_i,
  input  logic [DW-1:0]      wofs_i,
  input  logic [2*DW-1:0]    base_i,
  input  logic               msi_valid_i,
  input  logic [VEC_W-1:0]   msi_vec_i,
  output logic               msi_ready_o,
  output logic               mem_req_o,
  output logic [2*DW-1:0]    mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  input  logic               mem_ack_i,
  output logic               wofs_inc_o,
  output logic               rofs_inc_o,
  output logic               ovf_set_o
);
  localparam logic [DW-1:0] STEP = DW'(ENTRY_BYTES);

  logic pend_q, push_rd_q;
  logic accept, full, log_it;

  assign msi_ready_o = !pend_q;
  assign accept      = msi_valid_i && msi_ready_o;
  assign full        = full_det_i && (((wofs_i + STEP) & mask_i) == (rofs_i & mask_i));
  assign log_it      = accept && en_i && !(full && stop_i);
  assign ovf_set_o   = accept && en_i && full && stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; push_rd_q <= 1'b0;
      mem_addr_o <= '0; mem_data_o <= '0;
    end else if (log_it) begin
      pend_q     <= 1'b1;
      push_rd_q  <= full;
      mem_addr_o <= base_i + {{DW{1'b0}}, wofs_i & mask_i};
      mem_data_o <= {{(ENTRY_W-VEC_W){1'b0}}, msi_vec_i};
    end else if (pend_q && mem_ack_i) begin
      pend_q    <= 1'b0;
      push_rd_q <= 1'b0;
    end
  end

  assign mem_req_o  = pend_q;
  assign wofs_inc_o = pend_q && mem_ack_i;
  assign rofs_inc_o = pend_q && mem_ack_i && push_rd_q;

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));
  // R4
  data_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_data_o[ENTRY_W-1:VEC_W] == '0);
  // R7
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !en_i |=> !mem_req_o);
endmodule

// File: rtl/msi_ring_logger.sv
module msi_ring_logger
  import msi_ring_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int MIN_EXP = 15,
  parameter int VEC_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               msi_valid_i,
  input  logic [VEC_W-1:0]   msi_vec_i,
  output logic               msi_ready_o,
  output logic               mem_req_o,
  output logic [2*DW-1:0]    mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  input  logic               mem_ack_i,
  output logic               irq_o
);
  logic en, full_det, irq_en, stop;
  logic wofs_inc, rofs_inc, ovf_set;
  logic [2*DW-1:0] base;
  logic [DW-1:0] rofs, wofs, mask;

  msi_ring_regs #(.SEL_W(SEL_W), .MIN_EXP(MIN_EXP)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .hw_wofs_inc_i(wofs_inc), .hw_rofs_inc_i(rofs_inc), .hw_ovf_set_i(ovf_set),
    .en_o(en), .full_det_o(full_det), .irq_en_o(irq_en), .stop_o(stop),
    .base_o(base), .rofs_o(rofs), .wofs_o(wofs), .mask_o(mask)
  );

  msi_ring_writer #(.VEC_W(VEC_W)) u_wr (
    .clk_i, .rst_ni, .en_i(en), .full_det_i(full_det), .stop_i(stop),
    .mask_i(mask), .rofs_i(rofs), .wofs_i(wofs), .base_i(base),
    .msi_valid_i, .msi_vec_i, .msi_ready_o,
    .mem_req_o, .mem_addr_o, .mem_data_o, .mem_ack_i,
    .wofs_inc_o(wofs_inc), .rofs_inc_o(rofs_inc), .ovf_set_o(ovf_set)
  );

  assign irq_o = en && irq_en && ((rofs & mask) != (wofs & mask));

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mem_ack_i) || $past(reg_we_i));
endmodule

// File: tb/sim_msi_ring_logger.sv
module sim_msi_ring_logger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msi_valid = 1'b0, msi_ready;
  logic [15:0] msi_vec = '0;
  logic mem_req, mem_ack = 1'b0, irq;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  int n_chk = 0, n_fail = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

  always #5 clk = ~clk;

  msi_ring_logger u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .msi_valid_i(msi_valid),
    .msi_vec_i(msi_vec), .msi_ready_o(msi_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  function automatic logic [31:0] ctl(input bit en, full, irqe, stop, input int sel);
    return {22'd0, 2'(sel), 3'd0, stop, irqe, 1'b0, full, en};
  endfunction

  // log one vector; optional register write in the acknowledge cycle
  task automatic msi_log(input logic [15:0] vec, input logic [63:0] exp_addr,
                         input bit coll, input logic [2:0] ca, input logic [31:0] cd);
    logic [63:0] a0;
    while (!msi_ready) @(negedge clk);
    msi_valid = 1'b1; msi_vec = vec;
    @(negedge clk);
    msi_valid = 1'b0;
    check("R5 req raised", mem_req, 1);
    check("R5 ready low", msi_ready, 0);
    check("R3 entry address", mem_addr, exp_addr);
    check("R4 entry data", mem_data, {112'd0, vec});
    a0 = mem_addr;
    @(negedge clk);
    check("R5 req held", {mem_req, mem_addr}, {1'b1, a0});
    mem_ack = 1'b1;
    if (coll) begin reg_we = 1'b1; reg_addr = ca; reg_wdata = cd; end
    @(negedge clk);
    mem_ack = 1'b0; reg_we = 1'b0;
    check("R5 released", {mem_req, msi_ready}, 2'b01);
  endtask

  task automatic msi_drop(input logic [15:0] vec, input string tag);
    while (!msi_ready) @(negedge clk);
    msi_valid = 1'b1; msi_vec = vec;
    @(negedge clk);
    msi_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(tag, mem_req, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 outputs", {irq, mem_req, msi_ready}, 3'b001);
    rd_chk("R1 ctrl", 3'd0, 0);
    rd_chk("R1 base", 3'd4, 0);
    rd_chk("R1 rofs", 3'd5, 0);
    rd_chk("R1 wofs", 3'd6, 0);

    // R2 field map and alignment
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl fields", 3'd0, 32'h0000_031B);
    wr(3'd4, 32'h8000_000F);
    rd_chk("R2 base lo align", 3'd4, 32'h8000_0000);
    wr(3'd3, 32'h0000_0001);
    rd_chk("R2 base hi", 3'd3, 32'h0000_0001);
    wr(3'd5, 32'h0000_0123);
    rd_chk("R2 rofs align", 3'd5, 32'h0000_0120);
    rd_chk("R2 unused", 3'd1, 0);

    // R3/R6/R8 sweep over every size
    for (int sel = 0; sel < 4; sel++) begin
      logic [31:0] size, mask, raw0;
      size = 32'd1 << (sel + 15);
      mask = (size - 1) & ~32'hF;
      raw0 = 32'h0010_0000 + size - 16;
      wr(3'd0, ctl(1, 0, 1, 0, sel));
      wr(3'd6, raw0);
      wr(3'd5, raw0);
      check("R8 empty no irq", irq, 0);
      msi_log(16'hA500 + 16'(sel), BASE + {32'd0, raw0 & mask}, 0, 0, 0);
      check("R8 irq pending", irq, 1);
      rd_chk("R6 wofs +16", 3'd6, raw0 + 16);
      msi_log(16'hFFFF - 16'(sel), BASE, 0, 0, 0);
      rd_chk("R6 raw no wrap", 3'd6, raw0 + 32);
      wr(3'd5, raw0 + 32);
      check("R8 consumed", irq, 0);
    end

    // R4 vector patterns, R8 enable bits
    wr(3'd0, ctl(1, 1, 1, 0, 2));
    wr(3'd6, 0); wr(3'd5, 0);
    msi_log(16'h0001, BASE, 0, 0, 0);
    msi_log(16'h8000, BASE + 16, 0, 0, 0);
    msi_log(16'h1234, BASE + 32, 0, 0, 0);
    check("R8 irq set", irq, 1);
    wr(3'd0, ctl(1, 1, 0, 0, 2));
    check("R8 irq_en off", irq, 0);
    rd_chk("R8 ctrl kept", 3'd0, ctl(1, 1, 0, 0, 2));
    wr(3'd0, ctl(0, 1, 1, 0, 2));
    check("R8 en off", irq, 0);

    // R7 disabled
    msi_drop(16'h0042, "R7 no request");
    rd_chk("R7 wofs held", 3'd6, 48);
    check("R7 ready", msi_ready, 1);

    // R11 no full check
    wr(3'd0, ctl(1, 0, 0, 1, 0));
    wr(3'd6, 0); wr(3'd5, 32);
    msi_log(16'h0011, BASE, 0, 0, 0);
    msi_log(16'h0022, BASE + 16, 0, 0, 0);
    msi_log(16'h0033, BASE + 32, 0, 0, 0);
    rd_chk("R11 rofs kept", 3'd5, 32);

    // R9 stop on full
    wr(3'd0, ctl(1, 1, 1, 1, 0));
    wr(3'd6, 0); wr(3'd5, 32);
    msi_log(16'h0101, BASE, 0, 0, 0);
    msi_drop(16'h0202, "R9 dropped");
    rd_chk("R9 wofs held", 3'd6, 16);
    rd_chk("R9 overflow set", 3'd0, ctl(1, 1, 1, 1, 0) | 32'h1_0000);
    wr(3'd0, ctl(1, 1, 1, 1, 0) | 32'h1_0000);
    rd_chk("R9 overflow clear", 3'd0, ctl(1, 1, 1, 1, 0));

    // R10 overwrite oldest
    wr(3'd0, ctl(1, 1, 1, 0, 0));
    wr(3'd6, 0); wr(3'd5, 32);
    msi_log(16'h0303, BASE, 0, 0, 0);
    rd_chk("R10 not yet full", 3'd5, 32);
    msi_log(16'h0404, BASE + 16, 0, 0, 0);
    rd_chk("R10 rofs pushed", 3'd5, 48);
    rd_chk("R10 wofs", 3'd6, 32);
    check("R10 irq", irq, 1);

    // R12 software beats hardware in the same cycle
    wr(3'd0, ctl(1, 0, 1, 0, 0));
    wr(3'd6, 0); wr(3'd5, 0);
    msi_log(16'h0505, BASE, 1, 3'd5, 32'h40);
    rd_chk("R12 rofs sw", 3'd5, 32'h40);
    rd_chk("R12 wofs hw", 3'd6, 16);
    check("R12 irq", irq, 1);
    msi_log(16'h0606, BASE + 16, 1, 3'd6, 32'h200);
    rd_chk("R12 wofs sw", 3'd6, 32'h200);

    // R10/R12 overwrite push lost to software read-offset write
    wr(3'd0, ctl(1, 1, 0, 0, 0));
    wr(3'd6, 0); wr(3'd5, 16);
    msi_log(16'h0707, BASE, 1, 3'd5, 32'h80);
    rd_chk("R12 rofs over push", 3'd5, 32'h80);

    rd(3'd0, v);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule